// File: doc/BRIEF.md
# Dithered DAC Code Requantizer

This block turns a fine code into a code for a 12-bit DAC. The fine code has an integer part and a fractional part that lies below the DAC's LSB. On every update strobe it produces one coarse code. Over many updates, the mean of the emitted codes follows the full-resolution input, so an analog low-pass filter after the DAC can recover the fractional value. This matters for very slow ramps, where the input changes by much less than one DAC step between updates.

When dithering is enabled, the block keeps the quantization error in a signed residual register and adds it to the next input. This error feedback gives first-order noise shaping, and it needs no random source. A deterministic sawtooth offset can also be added before quantization. Its span is 2, 4 or 8 LSB, set by a 2-bit spread code. The offset moves the output across several DAC codes, which averages out step-size errors near major code transitions. Because the error feedback also includes the added offset, the long-term mean stays exact.

When dithering is disabled, the output is the integer part of the input.

Top module: `dac_dither_requant`

## Requirements
- R1: While reset is asserted, and directly after it, `code_o` is 0 and `valid_o` is 0.
- R2: Each cycle with `upd_i` high causes exactly one `valid_o` pulse in the next cycle. `code_o` changes only together with that pulse.
- R3: `code_i` is `{integer[11:0], fraction[7:0]}`. On an update with `dith_en_i` low, `code_o` becomes `code_i[19:8]` whatever `spread_i` is. The same update also clears the residual and the sawtooth phase, so the next dithered run starts from a known state.
- R4: With dithering on and `spread_i` = 0, each output is the integer part N or N+1. The pattern follows the fraction from a cleared state: fraction 0x40 repeats N,N,N,N+1; fraction 0x80 alternates N,N+1; fraction 0 holds N.
- R5: `spread_i` = s (1..3) adds a sawtooth offset spanning 2^s LSB. At s = 3 every output stays within N-8..N+8 and the outputs span at least 4 codes.
- R6: From a cleared state, over K dithered updates, the sum of outputs times 256 differs from K times the 20-bit input by no more than 6*256 at s = 3, and by no more than 3*256 at s = 1.
- R7: The output saturates at 0 and 4095 instead of wrapping. A clipped update clears the residual.
- R8: The same input sequence from a cleared state always produces the same output sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_i | input | 1 | Update strobe, one per DAC update |
| code_i | input | 20 | Fine code: integer[19:8], fraction[7:0] |
| dith_en_i | input | 1 | 1 = dither with error feedback, 0 = truncate and clear state |
| spread_i | input | 2 | Sawtooth spread code: 0 none, s spans 2^s LSB |
| code_o | output | 12 | Coarse DAC code |
| valid_o | output | 1 | One-cycle pulse marking a new code |

## Verification
Every result comes one clock after the edge that samples `upd_i`: the new code and the `valid_o` pulse appear together. The bench raises `upd_i` at a falling edge. It reads `code_o` and `valid_o` at the next falling edge, half a period after the registering edge. For back-to-back updates it keeps the strobe high, so each successive falling edge yields one new code to compare against the expected sequence. The stability check reads the outputs one further falling edge later, with the strobe low.

// File: rtl/dqz_pkg.sv
package dqz_pkg;

  typedef enum logic [1:0] {
    CLIP_NONE = 2'd0,
    CLIP_LOW  = 2'd1,
    CLIP_HIGH = 2'd2
  } clip_e;

  // Largest spread exponent encodable in a field of the given width
  function automatic int max_spread(input int spread_w);
    return (1 << spread_w) - 1;
  endfunction

  // Residual width: fraction bits plus headroom for the largest offset
  function automatic int resid_width(input int frac_w, input int spread_w);
    return frac_w + max_spread(spread_w) + 2;
  endfunction

endpackage

// File: rtl/dqz_pattern.sv
module dqz_pattern #(
  parameter int FRAC_W   = 8,
  parameter int PH_W     = 3,
  parameter int SPREAD_W = 2,
  parameter int AW       = 26
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv_i,
  input  logic                 clr_i,
  input  logic [SPREAD_W-1:0]  spread_i,
  output logic signed [AW-1:0] dith_o
);

  localparam logic signed [AW-1:0] HALF_S = AW'(1 << (PH_W - 1));
  localparam int                   BASE_SH = FRAC_W - PH_W;

  logic [PH_W-1:0]        phase_q;
  logic [PH_W-1:0]        phase_d;
  logic signed [AW-1:0]   centered;

  // Next phase: cleared in truncation mode, ramps once per dithered update
  always_comb begin
    phase_d = phase_q;
    if (clr_i) begin
      phase_d = '0;
    end else if (adv_i) begin
      phase_d = phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (clr_i || adv_i) begin
      phase_q <= phase_d;
    end
  end

  // Centered sawtooth scaled so its span is 2^spread LSB
  always_comb begin
    centered = $signed({{(AW-PH_W){1'b0}}, phase_q}) - HALF_S;
    if (spread_i == '0) begin
      dith_o = '0;
    end else begin
      dith_o = centered <<< (BASE_SH + int'(spread_i));
    end
  end

endmodule

// File: rtl/dqz_quant.sv
module dqz_quant
  import dqz_pkg::*;
#(
  parameter int OUT_W    = 12,
  parameter int FRAC_W   = 8,
  parameter int SPREAD_W = 2,
  parameter int AW       = 26
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ld_i,
  input  logic                     clr_i,
  input  logic [OUT_W+FRAC_W-1:0]  code_i,
  input  logic signed [AW-1:0]     dith_i,
  output logic [OUT_W-1:0]         y_o,
  output clip_e                    clip_o
);

  localparam int IN_W = OUT_W + FRAC_W;
  localparam int EW   = resid_width(FRAC_W, SPREAD_W);
  localparam logic signed [AW-1:0] MAX_S = AW'((1 << OUT_W) - 1);

  logic signed [EW-1:0] resid_q;
  logic signed [EW-1:0] resid_d;
  logic signed [EW-1:0] err;
  logic signed [AW-1:0] x_s;
  logic signed [AW-1:0] r_s;
  logic signed [AW-1:0] v;
  logic signed [AW-1:0] w;
  logic signed [AW-1:0] q;

  // Error feedback sum, offset, and floor division by 2^FRAC_W
  always_comb begin
    x_s = $signed({{(AW-IN_W){1'b0}}, code_i});
    r_s = {{(AW-EW){resid_q[EW-1]}}, resid_q};
    v   = x_s + r_s;
    w   = v + dith_i;
    q   = w >>> FRAC_W;
  end

  // Saturating quantizer; clipped updates drop the error
  always_comb begin
    if (w < 0) begin
      clip_o = CLIP_LOW;
      y_o    = '0;
      err    = '0;
    end else if (q > MAX_S) begin
      clip_o = CLIP_HIGH;
      y_o    = {OUT_W{1'b1}};
      err    = '0;
    end else begin
      clip_o = CLIP_NONE;
      y_o    = OUT_W'(q);
      err    = EW'(v - (q <<< FRAC_W));
    end
  end

  always_comb begin
    resid_d = resid_q;
    if (clr_i) begin
      resid_d = '0;
    end else if (ld_i) begin
      resid_d = err;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resid_q <= '0;
    end else if (clr_i || ld_i) begin
      resid_q <= resid_d;
    end
  end

endmodule

// File: rtl/dac_dither_requant.sv
module dac_dither_requant
  import dqz_pkg::*;
#(
  parameter int OUT_W    = 12,
  parameter int FRAC_W   = 8,
  parameter int SPREAD_W = 2,
  parameter int PH_W     = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     upd_i,
  input  logic [OUT_W+FRAC_W-1:0]  code_i,
  input  logic                     dith_en_i,
  input  logic [SPREAD_W-1:0]      spread_i,
  output logic [OUT_W-1:0]         code_o,
  output logic                     valid_o
);

  localparam int IN_W = OUT_W + FRAC_W;
  localparam int AW   = IN_W + max_spread(SPREAD_W) + 3;

  logic                 dith_upd;
  logic                 trunc_upd;
  logic signed [AW-1:0] dith;
  logic [OUT_W-1:0]     y_dith;
  clip_e                clip;
  logic [OUT_W-1:0]     code_q;
  logic [OUT_W-1:0]     code_d;
  logic                 valid_q;
  logic                 valid_d;

  assign dith_upd  = upd_i &  dith_en_i;
  assign trunc_upd = upd_i & ~dith_en_i;

  dqz_pattern #(
    .FRAC_W   (FRAC_W),
    .PH_W     (PH_W),
    .SPREAD_W (SPREAD_W),
    .AW       (AW)
  ) pattern_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv_i    (dith_upd),
    .clr_i    (trunc_upd),
    .spread_i (spread_i),
    .dith_o   (dith)
  );

  dqz_quant #(
    .OUT_W    (OUT_W),
    .FRAC_W   (FRAC_W),
    .SPREAD_W (SPREAD_W),
    .AW       (AW)
  ) quant_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld_i   (dith_upd),
    .clr_i  (trunc_upd),
    .code_i (code_i),
    .dith_i (dith),
    .y_o    (y_dith),
    .clip_o (clip)
  );

  always_comb begin
    valid_d = upd_i;
    code_d  = code_q;
    if (dith_upd) begin
      code_d = y_dith;
    end else if (trunc_upd) begin
      code_d = code_i[IN_W-1:FRAC_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      if (upd_i) begin
        code_q <= code_d;
      end
    end
  end

  assign code_o  = code_q;
  assign valid_o = valid_q;

endmodule

// File: rtl/dac_dither_requant_chk.sv
module dac_dither_requant_chk #(
  parameter int OUT_W    = 12,
  parameter int FRAC_W   = 8,
  parameter int SPREAD_W = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     upd_i,
  input logic [OUT_W+FRAC_W-1:0]  code_i,
  input logic                     dith_en_i,
  input logic [SPREAD_W-1:0]      spread_i,
  input logic [OUT_W-1:0]         code_o,
  input logic                     valid_o
);

  localparam int IN_W = OUT_W + FRAC_W;

  always_comb begin
    if (!rst_n) begin
      assert_reset_idle_R1: assert (code_o == '0 && !valid_o);
    end
  end

  assert_pulse_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    upd_i |=> valid_o);

  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_i |=> !valid_o);

  assert_hold_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(code_o));

  assert_truncate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && !dith_en_i) |=> code_o == $past(code_i[IN_W-1:FRAC_W]));

  assert_first_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && dith_en_i && spread_i == '0) |=>
      (code_o == $past(code_i[IN_W-1:FRAC_W])) ||
      (code_o == $past(code_i[IN_W-1:FRAC_W]) + 1'b1));

endmodule

bind dac_dither_requant dac_dither_requant_chk #(
  .OUT_W    (OUT_W),
  .FRAC_W   (FRAC_W),
  .SPREAD_W (SPREAD_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .upd_i     (upd_i),
  .code_i    (code_i),
  .dith_en_i (dith_en_i),
  .spread_i  (spread_i),
  .code_o    (code_o),
  .valid_o   (valid_o)
);

// File: tb/dac_dither_requant_tb_top.sv
module dac_dither_requant_tb_top;

  logic        clk;
  logic        rst_n;
  logic        upd_i;
  logic [19:0] code_i;
  logic        dith_en_i;
  logic [1:0]  spread_i;
  logic [11:0] code_o;
  logic        valid_o;

  int checks;
  int errors;
  bit done;

  dac_dither_requant dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_i     (upd_i),
    .code_i    (code_i),
    .dith_en_i (dith_en_i),
    .spread_i  (spread_i),
    .code_o    (code_o),
    .valid_o   (valid_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One update: strobe at a falling edge, read result at the next falling edge
  task automatic step(input logic [19:0] x, input logic en, input logic [1:0] s,
                      output logic [11:0] y);
    code_i    = x;
    dith_en_i = en;
    spread_i  = s;
    upd_i     = 1'b1;
    @(negedge clk);
    upd_i = 1'b0;
    y     = code_o;
  endtask

  task automatic clear_state(input logic [19:0] x);
    logic [11:0] y;
    step(x, 1'b0, 2'd0, y);
  endtask

  task automatic t_latency();
    logic [11:0] y;
    step({12'h2A5, 8'h80}, 1'b0, 2'd0, y);
    chk(valid_o == 1'b1, "R2 pulse", int'(valid_o), 1);
    chk(y == 12'h2A5, "R3 truncate", int'(y), 'h2A5);
    @(negedge clk);
    chk(valid_o == 1'b0, "R2 single pulse", int'(valid_o), 0);
    chk(code_o == 12'h2A5, "R2 hold", int'(code_o), 'h2A5);
  endtask

  task automatic t_truncate();
    logic [11:0] y;
    step(20'hFFFFF, 1'b0, 2'd3, y);
    chk(y == 12'hFFF, "R3 max", int'(y), 4095);
    step(20'h00001, 1'b0, 2'd3, y);
    chk(y == 12'h000, "R3 tiny", int'(y), 0);
    step(20'h800FF, 1'b0, 2'd2, y);
    chk(y == 12'h800, "R3 mid", int'(y), 'h800);
  endtask

  task automatic t_first_order();
    logic [11:0] y;
    clear_state(20'd0);
    for (int i = 0; i < 8; i++) begin
      step({12'd1000, 8'h40}, 1'b1, 2'd0, y);
      chk(y == ((i % 4 == 3) ? 12'd1001 : 12'd1000), "R4 quarter", int'(y),
          (i % 4 == 3) ? 1001 : 1000);
    end
    clear_state(20'd0);
    for (int i = 0; i < 6; i++) begin
      step({12'd1000, 8'h80}, 1'b1, 2'd0, y);
      chk(y == ((i % 2 == 1) ? 12'd1001 : 12'd1000), "R4 half", int'(y),
          (i % 2 == 1) ? 1001 : 1000);
    end
    clear_state(20'd0);
    for (int i = 0; i < 4; i++) begin
      step({12'd777, 8'h00}, 1'b1, 2'd0, y);
      chk(y == 12'd777, "R4 integer", int'(y), 777);
    end
  endtask

  task automatic t_clear();
    logic [11:0] y;
    clear_state(20'd0);
    step({12'd1000, 8'h40}, 1'b1, 2'd0, y);
    step({12'd1000, 8'h40}, 1'b1, 2'd0, y);
    step({12'd1000, 8'h40}, 1'b0, 2'd0, y);
    chk(y == 12'd1000, "R3 clear truncate", int'(y), 1000);
    for (int i = 0; i < 4; i++) begin
      step({12'd1000, 8'h40}, 1'b1, 2'd0, y);
      chk(y == ((i == 3) ? 12'd1001 : 12'd1000), "R3 residual cleared", int'(y),
          (i == 3) ? 1001 : 1000);
    end
  endtask

  task automatic t_spread(input logic [11:0] n, input logic [7:0] f,
                          input logic [1:0] s, input int bound);
    logic [11:0] y;
    int sum;
    int lo;
    int hi;
    int diff;
    bit in_range;
    sum = 0;
    lo = 4095;
    hi = 0;
    in_range = 1'b1;
    clear_state(20'd0);
    for (int i = 0; i < 256; i++) begin
      step({n, f}, 1'b1, s, y);
      sum += int'(y);
      if (int'(y) < lo) lo = int'(y);
      if (int'(y) > hi) hi = int'(y);
      if (int'(y) < int'(n) - 8 || int'(y) > int'(n) + 8) in_range = 1'b0;
    end
    diff = sum * 256 - 256 * int'({n, f});
    if (diff < 0) diff = -diff;
    chk(diff <= bound, "R6 mean tracks input", diff, bound);
    if (s == 2'd3) begin
      chk(in_range, "R5 output window", hi, int'(n) + 8);
      chk(hi - lo >= 4, "R5 spread width", hi - lo, 4);
    end
  endtask

  task automatic t_saturate();
    logic [11:0] y;
    int lo;
    int hi;
    bit top_seen;
    clear_state(20'd0);
    lo = 4095;
    top_seen = 1'b0;
    for (int i = 0; i < 64; i++) begin
      step(20'hFFFFF, 1'b1, 2'd3, y);
      if (int'(y) < lo) lo = int'(y);
      if (y == 12'hFFF) top_seen = 1'b1;
    end
    chk(lo >= 4087, "R7 no wrap high", lo, 4087);
    chk(top_seen, "R7 reaches 4095", int'(top_seen), 1);
    clear_state(20'd0);
    hi = 0;
    for (int i = 0; i < 64; i++) begin
      step(20'd0, 1'b1, 2'd3, y);
      if (int'(y) > hi) hi = int'(y);
    end
    chk(hi <= 8, "R7 no wrap low", hi, 8);
  endtask

  task automatic t_repeat();
    logic [11:0] y;
    logic [11:0] first [16];
    clear_state(20'd0);
    for (int i = 0; i < 16; i++) begin
      step({12'd3000, 8'hC3}, 1'b1, 2'd2, y);
      first[i] = y;
    end
    clear_state(20'd0);
    for (int i = 0; i < 16; i++) begin
      step({12'd3000, 8'hC3}, 1'b1, 2'd2, y);
      chk(y == first[i], "R8 repeatable", int'(y), int'(first[i]));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    checks    = 0;
    errors    = 0;
    done      = 1'b0;
    rst_n     = 1'b0;
    upd_i     = 1'b0;
    code_i    = '0;
    dith_en_i = 1'b0;
    spread_i  = '0;
    repeat (3) @(negedge clk);
    chk(code_o == 12'd0 && valid_o == 1'b0, "R1 reset state", int'(code_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(code_o == 12'd0 && valid_o == 1'b0, "R1 after release", int'(valid_o), 0);
    t_latency();
    t_truncate();
    t_first_order();
    t_clear();
    t_spread(12'd2000, 8'h5B, 2'd3, 6 * 256);
    t_spread(12'd1234, 8'hA7, 2'd1, 3 * 256);
    t_saturate();
    t_repeat();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule